// File: doc/BRIEF.md
# Flash Array Program and Erase Engine

This block is the execution half of a word-wide NOR flash model. A command decoder hands it one request at a time: program a word, erase the main region, erase the whole chip, or set the boot-region lock. The engine writes a behavioural array, holds a busy flag for a fixed number of clock cycles, and while busy answers reads with status bits in place of bit 7 and bit 6.

The lowest eighth of the array is the boot region; the rest is the main region. With the default `ADDR_W` of 10 the boot region is words 000h to 07Fh and the main region is words 080h to 3FFh. A lock flag, once set, shields the boot region from every later program and erase until reset.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset `busy` is 0, `boot_locked` is 0 and `rd_data` is 0.
- R2: A program (req_op 0) stores old word AND supplied data, so it can only clear bits; `busy` stays high for exactly `PROG_CYC` cycles after the accepting edge.
- R3: A main erase (req_op 1) sets every main-region word to all ones, leaves the boot region unchanged, and holds `busy` high for `ERASE_CYC` cycles (never fewer than the array depth).
- R4: A chip erase (req_op 2) with the lock clear sets every word, boot region included, to all ones.
- R5: A lock request (req_op 3) raises `boot_locked` on the accepting edge and it stays high until reset; afterwards a program to a boot address leaves the word unchanged and a chip erase clears only the main region.
- R6: While a program is busy, a read of the address it loaded returns bit 7 as the inverse of the loaded bit 7.
- R7: While busy, bit 6 of the read data is 0 on the first read after the request is accepted and inverts on each following read; when idle, bit 6 is the stored bit.
- R8: A request presented while `busy` is high is dropped: it changes no word and does not restart the busy count.
- R9: A read with `busy` low returns the stored word on `rd_data` one clock after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 0 program, 1 main erase, 2 chip erase, 3 lock |
| req_addr | input | ADDR_W | Word address for a program |
| req_data | input | DATA_W | Data for a program |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read data or status |
| busy | output | 1 | High while an operation runs |
| boot_locked | output | 1 | Boot-region lock flag |

## Verification
A wrong busy count shows as a busy window that is short or long by the error, visible at the first edge where `busy` should change, and a restarted count on a dropped request stretches the window. A bad sweep pointer or region start shows as a word left unerased or a boot word wrongly cleared, seen on the first idle read after the erase. A toggle flop that is not cleared on acceptance or that flips on idle reads shows on the first one or two status reads, and a stale polled address shows as bit 7 inverted on the wrong word.

// File: rtl/fpe_pkg.sv
// Shared types for the flash program/erase engine.
// Assumes: a two-bit request code chosen by the command decoder.
package fpe_pkg;
    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_MAIN_ERASE = 2'd1,
        OP_CHIP_ERASE = 2'd2,
        OP_LOCK       = 2'd3
    } fpe_op_e;
endpackage

// File: rtl/fpe_busy_timer.sv
// Down-counter that produces the busy window of an operation.
// Assumes: load is only raised while idle; a load value of N gives N busy cycles.
module fpe_busy_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt;

    // Load on a new operation, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !load |=> cnt == $past(cnt) - 1'b1); // R2
    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R8
endmodule

// File: rtl/fpe_word_array.sv
// Behavioural word array: one write port and two combinational read ports.
// Assumes: contents are undefined until the first erase; no reset on storage.
module fpe_word_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Single write port shared by programming and the erase sweep.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/fpe_read_status.sv
// Read path: true data when idle; bit 7 polling and bit 6 toggle when busy.
// Assumes: clear_tog only pulses on an accepting edge, when busy is low.
module fpe_read_status #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] word,
    input  logic              busy,
    input  logic              clear_tog,
    input  logic              poll_en,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic              poll_bit,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;

    logic              tog;
    logic [DATA_W-1:0] view;

    // Toggle state: cleared on each new operation, flips on every busy read.
    always_ff @(posedge clk) begin
        if (!rst_n)              tog <= 1'b0;
        else if (clear_tog)      tog <= 1'b0;
        else if (rd_en && busy)  tog <= ~tog;
    end

    // Compose the word seen by the reader.
    always_comb begin
        view = word;
        if (busy) begin
            view[TOG_BIT] = tog;
            if (poll_en && (rd_addr == poll_addr)) view[POLL_BIT] = ~poll_bit;
        end
    end

    // Register the read result.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= view;
    end

    AST_IDLE_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !busy |=> rd_data == $past(word)); // R9
endmodule

// File: rtl/flash_pe_engine.sv
// Program/erase engine for a word-wide NOR flash model.
// Accepts one request when idle, writes the array (program at once, erase as
// a one-word-per-cycle sweep during the busy window) and guards the boot
// region with a sticky lock. Assumes requests are single-cycle strobes.
module flash_pe_engine #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int BOOT_SHIFT = 3,
    parameter int PROG_CYC   = 8,
    parameter int ERASE_CYC  = 1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              boot_locked
);
    import fpe_pkg::*;

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BOOT_DEPTH = DEPTH >> BOOT_SHIFT;
    localparam int ERASE_DUR  = (ERASE_CYC > DEPTH) ? ERASE_CYC : DEPTH;
    localparam int CNT_W      = $clog2(ERASE_DUR + 1);
    localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'(BOOT_DEPTH);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    fpe_op_e           op_in;
    fpe_op_e           cur_op;
    logic              accept;
    logic              is_erase;
    logic              prog_ok;
    logic              locked;
    logic              sweeping;
    logic [ADDR_W-1:0] sweep_ptr;
    logic [ADDR_W-1:0] last_addr;
    logic              last_bit7;
    logic [CNT_W-1:0]  dur;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] rd_word;

    assign op_in    = fpe_op_e'(req_op);
    assign accept   = req_valid && !busy;
    assign is_erase = (op_in == OP_MAIN_ERASE) || (op_in == OP_CHIP_ERASE);
    assign prog_ok  = !(locked && (req_addr < BOOT_BASE));
    assign dur      = is_erase ? CNT_W'(ERASE_DUR) : CNT_W'(PROG_CYC);

    // Operation record: current code, polled address and loaded bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op    <= OP_PROG;
            last_addr <= '0;
            last_bit7 <= 1'b0;
        end else if (accept) begin
            cur_op <= op_in;
            if (op_in == OP_PROG) begin
                last_addr <= req_addr;
                last_bit7 <= req_data[7];
            end
        end
    end

    // Sticky boot lock, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                          locked <= 1'b0;
        else if (accept && op_in == OP_LOCK) locked <= 1'b1;
    end

    // Erase sweep: start at the first unprotected word, end at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweeping  <= 1'b0;
            sweep_ptr <= '0;
        end else if (accept && is_erase) begin
            sweeping  <= 1'b1;
            sweep_ptr <= (op_in == OP_MAIN_ERASE || locked) ? BOOT_BASE : '0;
        end else if (sweeping) begin
            if (sweep_ptr == LAST_ADDR) sweeping  <= 1'b0;
            else                        sweep_ptr <= sweep_ptr + 1'b1;
        end
    end

    // Write port select: program on the accepting edge, else the sweep.
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = sweep_ptr;
        wr_data = '1;
        if (accept && op_in == OP_PROG) begin
            wr_en   = prog_ok;
            wr_addr = req_addr;
            wr_data = old_word & req_data;
        end else if (sweeping) begin
            wr_en = 1'b1;
        end
    end

    fpe_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (dur),
        .busy     (busy)
    );

    fpe_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ra_addr (req_addr),
        .ra_data (old_word),
        .rb_addr (rd_addr),
        .rb_data (rd_word)
    );

    fpe_read_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .word      (rd_word),
        .busy      (busy),
        .clear_tog (accept),
        .poll_en   (cur_op == OP_PROG),
        .poll_addr (last_addr),
        .poll_bit  (last_bit7),
        .rd_data   (rd_data)
    );

    assign boot_locked = locked;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R5
    AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        locked && wr_en |-> wr_addr >= BOOT_BASE); // R5
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R2
    AST_SWEEP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |-> busy); // R3
endmodule

// File: tb/sim_flash_pe_engine.sv
module sim_flash_pe_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int PROG_CYC = 8;
    localparam int ERASE_CYC = 1100;
    localparam int NV = 9;

    // Entry: {op[2], addr[10], data[16], check addr[10], expected[16]}
    localparam logic [53:0] VEC [NV] = '{
        {2'd2, 10'h000, 16'h0000, 10'h005, 16'hFFFF},  // R4 chip erase
        {2'd0, 10'h200, 16'h1234, 10'h200, 16'h1234},  // R2
        {2'd0, 10'h200, 16'hFF0F, 10'h200, 16'h1204},  // R2 AND only
        {2'd0, 10'h010, 16'hA5A5, 10'h010, 16'hA5A5},  // R2 boot word
        {2'd1, 10'h000, 16'h0000, 10'h200, 16'hFFFF},  // R3 main cleared
        {2'd0, 10'h3FF, 16'h00F0, 10'h010, 16'hA5A5},  // R3 boot kept
        {2'd0, 10'h080, 16'h8001, 10'h080, 16'h8001},  // R2 first main word
        {2'd2, 10'h000, 16'h0000, 10'h010, 16'hFFFF},  // R4 boot cleared
        {2'd0, 10'h07F, 16'h5A5A, 10'h07F, 16'h5A5A}   // R2 last boot word
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic          boot_locked;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    flash_pe_engine #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(PROG_CYC),
                      .ERASE_CYC(ERASE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .boot_locked(boot_locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin n = n + 1; @(negedge clk); end
    endtask

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] v2;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", {15'd0, busy}, 16'd0);
        check("R1 boot_locked", {15'd0, boot_locked}, 16'd0);
        check("R1 rd_data", rd_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][53:52], VEC[i][51:42], VEC[i][41:26]);
            wait_idle();
            rd(VEC[i][25:16], v);
            check($sformatf("R2/R3/R4 vector %0d", i), v, VEC[i][15:0]);
        end

        // R2 program busy window
        issue(2'd0, 10'h3FE, 16'hFFFF);
        count_busy(n);
        check("R2 program busy cycles", 16'(n), 16'(PROG_CYC));
        // R3 erase busy window
        issue(2'd1, 10'h000, 16'h0000);
        count_busy(n);
        check("R3 erase busy cycles", 16'(n), 16'(ERASE_CYC));

        // R6 / R7 polling during a program of 0x300 (erased word)
        issue(2'd0, 10'h300, 16'h0080);
        rd(10'h300, v);
        check("R6 R7 first busy read", v, 16'h0000);
        rd(10'h300, v);
        check("R7 second busy read", v, 16'h0040);
        rd(10'h301, v);
        check("R7 other address busy read", v, 16'hFFBF);
        // R8 request while busy is dropped
        issue(2'd0, 10'h301, 16'h0000);
        count_busy(n);
        check("R8 busy not restarted", 16'(n), 16'(PROG_CYC - 4));
        rd(10'h301, v);
        check("R8 dropped program", v, 16'hFFFF);
        rd(10'h300, v);
        rd(10'h300, v2);
        check("R9 idle read", v, 16'h0080);
        check("R7 no toggle when idle", v2, 16'h0080);

        // R5 lock behaviour
        issue(2'd0, 10'h080, 16'h1111);
        wait_idle();
        issue(2'd3, 10'h000, 16'h0000);
        check("R5 lock raised", {15'd0, boot_locked}, 16'd1);
        wait_idle();
        issue(2'd0, 10'h07F, 16'h0000);
        wait_idle();
        rd(10'h07F, v);
        check("R5 boot program blocked", v, 16'h5A5A);
        issue(2'd2, 10'h000, 16'h0000);
        wait_idle();
        rd(10'h07F, v);
        check("R5 chip erase keeps boot", v, 16'h5A5A);
        rd(10'h080, v);
        check("R5 chip erase clears main", v, 16'hFFFF);
        issue(2'd1, 10'h000, 16'h0000);
        wait_idle();
        issue(2'd0, 10'h3FF, 16'h1234);
        wait_idle();
        rd(10'h3FF, v);
        check("R5 main program under lock", v, 16'h1234);
        rd(10'h07F, v);
        check("R3 main erase keeps boot", v, 16'h5A5A);
        check("R5 lock sticky", {15'd0, boot_locked}, 16'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule